// File: doc/BRIEF.md
# Adjustable-Rate Timestamp Counter

This block keeps a nanosecond time count for precision time protocol hardware. Each reference tick, qualified by the tick strobe and the run control, adds a programmable increment to the count. To trim the rate, a second increment value replaces the normal one on a single tick out of every programmable number of ticks. Software can nudge the clock faster or slower this way without changing the reference clock.

The count can wrap at a programmable period instead of at its natural width. Each wrap raises a one-cycle pulse for compare channels, and a gated copy of that pulse serves as a compare event. Software reads the time through a capture step: a capture request copies the live count into a holding register, and that holding register is what a read of the time location returns. Software sets the time by writing the time location, which loads the count directly. All controls sit behind a small synchronous register bus with a one-cycle read latency.

Top module: `tsc_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, the count, the wrap pulse, the compare event, the read data and every register are zero.
- R2: The count adds the normal increment (INC register at word address 4, bits 6:0) on each clock edge where the tick input is high and control bit 0 is set. The count holds when either one is low.
- R3: With a non-zero value C in the correction register (address 3), every (C+1)th counting tick adds the correction increment (INC bits 14:8) instead of the normal one. Writing the correction register restarts this tick schedule from zero.
- R4: With the correction register at zero, every counting tick adds the normal increment.
- R5: With control bits 5 and 4 both set, a counting tick whose sum reaches or passes the PERIOD register (address 2) leaves the count at the sum minus the period. With either bit clear, the count wraps modulo 2^32.
- R6: The wrap output is high for exactly the one cycle after each edge on which such a period wrap happened, and is low otherwise.
- R7: The compare event output equals the wrap pulse when control bit 7 was set at the wrap, and stays low when it was clear.
- R8: Writing control (address 0) with bit 11 set copies the live count into the capture register on the next edge. Bit 11 reads back as 1 for that one cycle and then clears itself.
- R9: A read of the time location (address 1) returns the captured value, never the live count.
- R10: Writing the time location loads the written value into the count on that edge. The load takes precedence over a counting tick in the same cycle, and that tick does not advance the correction schedule.
- R11: The read data register updates on the edge where the read strobe is high, and holds otherwise. Unmapped addresses read 0. INC reads back only bits 14:8 and 6:0, and control reads back only bits 11, 7, 5, 4 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| count_o | output | 32 | Live time count |
| wrap_o | output | 1 | One-cycle period wrap pulse |
| cmp_evt_o | output | 1 | Wrap pulse gated by control bit 7 |

## Verification
The bench lands the correction tick exactly on the (C+1)th counting tick and restarts the schedule by rewriting the register. A design that was off by one there would drift the clock by one increment per period. Wraps are driven with a sum that overshoots the period, so a design that cleared the count to zero would lose the remainder. The bench also crosses the 2^32 boundary with wrapping disabled. A time load is issued in the same cycle as a tick, which exposes a design that adds the increment on top of the loaded value. The capture bit is read back in its single high cycle and again afterwards, and time reads are compared against the capture register rather than the moving count, which catches a design that returns the live count or leaves the capture bit set.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // control bit positions
  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_WEN0  = 4;
  localparam int unsigned CTL_WEN1  = 5;
  localparam int unsigned CTL_EVT   = 7;
  localparam int unsigned CTL_CAP   = 11;
  // lsb of correction increment field inside the increment register
  localparam int unsigned CORR_LSB  = 8;

  typedef enum logic [2:0] {
    TSC_A_CTRL   = 3'd0,
    TSC_A_TIME   = 3'd1,
    TSC_A_PERIOD = 3'd2,
    TSC_A_CORR   = 3'd3,
    TSC_A_INC    = 3'd4
  } tsc_addr_e;
endpackage

// File: rtl/tsc_regfile.sv
module tsc_regfile
  import tsc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned INC_W  = 7,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              wrap_en,
  output logic              evt_en,
  output logic              cap_pend,
  output logic [CNT_W-1:0]  period,
  output logic [DATA_W-1:0] corr_per,
  output logic [INC_W-1:0]  base_inc,
  output logic [INC_W-1:0]  corr_inc,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic              corr_restart
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic              run_q, evt_q, cap_q;
  logic [1:0]        wen_q;
  logic [CNT_W-1:0]  period_q, tcap_q;
  logic [DATA_W-1:0] corr_q, rdata_q, rd_mux, ctrl_word, inc_word;
  logic [INC_W-1:0]  binc_q, cinc_q;

  logic hit_ctrl, hit_time, hit_per, hit_corr, hit_inc;
  assign hit_ctrl = (addr == ADDR_W'(TSC_A_CTRL));
  assign hit_time = (addr == ADDR_W'(TSC_A_TIME));
  assign hit_per  = (addr == ADDR_W'(TSC_A_PERIOD));
  assign hit_corr = (addr == ADDR_W'(TSC_A_CORR));
  assign hit_inc  = (addr == ADDR_W'(TSC_A_INC));

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTL_RUN]  = run_q;
    ctrl_word[CTL_WEN0] = wen_q[0];
    ctrl_word[CTL_WEN1] = wen_q[1];
    ctrl_word[CTL_EVT]  = evt_q;
    ctrl_word[CTL_CAP]  = cap_q;
    inc_word = '0;
    inc_word[INC_W-1:0] = binc_q;
    inc_word[CORR_LSB +: INC_W] = cinc_q;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = ctrl_word;
    else if (hit_time) rd_mux = {{PAD_W{1'b0}}, tcap_q};
    else if (hit_per)  rd_mux = {{PAD_W{1'b0}}, period_q};
    else if (hit_corr) rd_mux = corr_q;
    else if (hit_inc)  rd_mux = inc_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      evt_q    <= 1'b0;
      cap_q    <= 1'b0;
      wen_q    <= 2'b00;
      period_q <= '0;
      tcap_q   <= '0;
      corr_q   <= '0;
      binc_q   <= '0;
      cinc_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (cap_q) begin
        tcap_q <= live_cnt;
        cap_q  <= 1'b0;
      end
      if (wr_en) begin
        if (hit_ctrl) begin
          run_q <= wdata[CTL_RUN];
          wen_q <= {wdata[CTL_WEN1], wdata[CTL_WEN0]};
          evt_q <= wdata[CTL_EVT];
          cap_q <= wdata[CTL_CAP];
        end
        if (hit_per)  period_q <= wdata[CNT_W-1:0];
        if (hit_corr) corr_q   <= wdata;
        if (hit_inc) begin
          binc_q <= wdata[INC_W-1:0];
          cinc_q <= wdata[CORR_LSB +: INC_W];
        end
      end
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata        = rdata_q;
  assign run          = run_q;
  assign wrap_en      = &wen_q;
  assign evt_en       = evt_q;
  assign cap_pend     = cap_q;
  assign period       = period_q;
  assign corr_per     = corr_q;
  assign base_inc     = binc_q;
  assign corr_inc     = cinc_q;
  assign load_stb     = wr_en & hit_time;
  assign load_val     = wdata[CNT_W-1:0];
  assign corr_restart = wr_en & hit_corr;
endmodule

// File: rtl/tsc_corr_sched.sv
module tsc_corr_sched #(
  parameter int unsigned SCH_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [SCH_W-1:0] corr_per,
  output logic             use_corr
);
  logic [SCH_W-1:0] tick_cnt_q;
  logic             active;

  assign active   = (corr_per != '0);
  assign use_corr = active && (tick_cnt_q == corr_per);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt_q <= '0;
    end else if (restart || !active) begin
      tick_cnt_q <= '0;
    end else if (step) begin
      if (use_corr) tick_cnt_q <= '0;
      else          tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tsc_count_core.sv
module tsc_count_core #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [INC_W-1:0] inc_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  input  logic             wrap_en,
  input  logic             evt_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             evt
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q, evt_q;
  logic [EXT_W-1:0] sum, rem;
  logic             hit;

  assign sum = {1'b0, cnt_q} + {{(EXT_W-INC_W){1'b0}}, inc_val};
  assign rem = sum - {1'b0, period};
  assign hit = wrap_en && (sum >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      evt_q  <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      wrap_q <= 1'b0;
      evt_q  <= 1'b0;
    end else if (step) begin
      cnt_q  <= hit ? rem[CNT_W-1:0] : sum[CNT_W-1:0];
      wrap_q <= hit;
      evt_q  <= hit & evt_en;
    end else begin
      wrap_q <= 1'b0;
      evt_q  <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = wrap_q;
  assign evt  = evt_q;
endmodule

// File: rtl/tsc_timer.sv
module tsc_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned INC_W  = 7,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o,
  output logic              cmp_evt_o
);
  logic              run_w, wrap_en_w, evt_en_w, cap_pend_w;
  logic              load_w, restart_w, use_corr_w, step_w;
  logic [CNT_W-1:0]  period_w, load_val_w;
  logic [DATA_W-1:0] corr_per_w;
  logic [INC_W-1:0]  base_inc_w, corr_inc_w, inc_sel_w;

  tsc_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
    .wdata(wdata_i), .live_cnt(count_o), .rdata(rdata_o), .run(run_w),
    .wrap_en(wrap_en_w), .evt_en(evt_en_w), .cap_pend(cap_pend_w),
    .period(period_w), .corr_per(corr_per_w), .base_inc(base_inc_w),
    .corr_inc(corr_inc_w), .load_stb(load_w), .load_val(load_val_w),
    .corr_restart(restart_w)
  );

  assign step_w    = tick_i & run_w & ~load_w;
  assign inc_sel_w = use_corr_w ? corr_inc_w : base_inc_w;

  tsc_corr_sched #(.SCH_W(DATA_W)) u_sched (
    .clk(clk), .rst(rst), .step(step_w), .restart(restart_w),
    .corr_per(corr_per_w), .use_corr(use_corr_w)
  );

  tsc_count_core #(.CNT_W(CNT_W), .INC_W(INC_W)) u_core (
    .clk(clk), .rst(rst), .step(step_w), .inc_val(inc_sel_w), .load(load_w),
    .load_val(load_val_w), .period(period_w), .wrap_en(wrap_en_w),
    .evt_en(evt_en_w), .cnt(count_o), .wrap(wrap_o), .evt(cmp_evt_o)
  );
endmodule

// File: rtl/tsc_timer_chk.sv
module tsc_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              wrap_o,
  input logic              cmp_evt_o,
  input logic              run_w,
  input logic              cap_pend_w,
  input logic [DATA_W-1:0] corr_per_w,
  input logic              use_corr_w
);
  logic time_wr, ctrl_cap_wr;
  assign time_wr     = wr_en_i && (addr_i == ADDR_W'(1));
  assign ctrl_cap_wr = wr_en_i && (addr_i == ADDR_W'(0)) && wdata_i[11];

  // R2: count holds without a tick and without a load
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !time_wr) |=> $stable(count_o));

  // R4: zero correction period never selects the correction increment
  p_nocorr_r4: assert property (@(posedge clk) disable iff (rst)
    (corr_per_w == '0) |-> !use_corr_w);

  // R6: a wrap pulse always follows a counting tick
  p_wrap_tick_r6: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> $past(tick_i && run_w && !time_wr));

  // R7: compare event only together with a wrap
  p_evt_gate_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_evt_o |-> wrap_o);

  // R8: pending capture clears itself unless rewritten
  p_cap_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_pend_w && !ctrl_cap_wr) |=> !cap_pend_w);

  // R10: a time write lands in the count
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    time_wr |=> (count_o == $past(wdata_i[CNT_W-1:0])));
endmodule

bind tsc_timer tsc_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .count_o(count_o), .wrap_o(wrap_o), .cmp_evt_o(cmp_evt_o),
  .run_w(run_w), .cap_pend_w(cap_pend_w), .corr_per_w(corr_per_w),
  .use_corr_w(use_corr_w)
);

// File: tb/tsc_timer_tb_top.sv
module tsc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, count_o;
  logic        wrap_o, cmp_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tsc_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .count_o(count_o),
    .wrap_o(wrap_o), .cmp_evt_o(cmp_evt_o)
  );

  // behavioural reference model
  logic [31:0] m_cnt, m_cap, m_per, m_corr, m_inc, m_rd, m_sch;
  logic        m_run, m_evt, m_capf, m_wrap, m_ev;
  logic [1:0]  m_wen;

  function automatic logic [31:0] ctrl_word();
    logic [31:0] w = 0;
    w[0] = m_run; w[5:4] = m_wen; w[7] = m_evt; w[11] = m_capf;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_per = 0; m_corr = 0; m_inc = 0; m_rd = 0; m_sch = 0;
      m_run = 0; m_evt = 0; m_capf = 0; m_wrap = 0; m_ev = 0; m_wen = 0;
    end else begin
      logic [31:0] o_cnt, o_corr, o_inc, o_per, o_sch;
      logic        o_run, o_evt, o_capf, corr_now;
      logic [1:0]  o_wen;
      longint      sum;
      int          inc;
      o_cnt = m_cnt; o_corr = m_corr; o_inc = m_inc; o_per = m_per; o_sch = m_sch;
      o_run = m_run; o_evt = m_evt; o_capf = m_capf; o_wen = m_wen;
      if (rd_en_i) begin
        case (addr_i)
          3'd0: m_rd = ctrl_word();
          3'd1: m_rd = m_cap;
          3'd2: m_rd = m_per;
          3'd3: m_rd = m_corr;
          3'd4: m_rd = m_inc;
          default: m_rd = 0;
        endcase
      end
      if (o_capf) begin m_cap = o_cnt; m_capf = 0; end
      if (wr_en_i) begin
        case (addr_i)
          3'd0: begin m_run = wdata_i[0]; m_wen = wdata_i[5:4]; m_evt = wdata_i[7]; m_capf = wdata_i[11]; end
          3'd2: m_per = wdata_i;
          3'd3: m_corr = wdata_i;
          3'd4: m_inc = wdata_i & 32'h7F7F;
          default: ;
        endcase
      end
      m_wrap = 0; m_ev = 0;
      if (wr_en_i && addr_i == 3'd1) begin
        m_cnt = wdata_i;
      end else if (tick_i && o_run) begin
        corr_now = (o_corr != 0) && (o_sch == o_corr);
        inc = corr_now ? int'(o_inc[14:8]) : int'(o_inc[6:0]);
        m_sch = (o_corr == 0 || corr_now) ? 0 : o_sch + 1;
        sum = longint'(o_cnt) + longint'(inc);
        if (o_wen == 2'b11 && sum >= longint'(o_per)) begin
          m_cnt = 32'(sum - longint'(o_per)); m_wrap = 1; m_ev = o_evt;
        end else m_cnt = 32'(sum);
      end
      if (o_corr == 0) m_sch = 0;
      if (wr_en_i && addr_i == 3'd3) m_sch = 0;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk(cur_req, count_o, m_cnt, "count");
    chk("R6", {31'b0, wrap_o}, {31'b0, m_wrap}, "wrap");
    chk("R7", {31'b0, cmp_evt_o}, {31'b0, m_ev}, "event");
    chk("R11", rdata_o, m_rd, "rdata");
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #2;
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #2;
    wr_en_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    rd_en_i = 1; addr_i = a;
    @(posedge clk); #2;
    rd_en_i = 0; d = rdata_o;
  endtask

  task automatic ticks(int n, bit alternate);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      tick_i = alternate ? ~tick_i : 1'b1;
    end
    @(posedge clk); #2;
    tick_i = 0;
  endtask

  task automatic report();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", count_o, 0, "count after reset");
    chk("R1", {30'b0, wrap_o, cmp_evt_o}, 0, "pulses after reset");
    chk("R1", rdata_o, 0, "rdata after reset");
    rd(3'd0, d); chk("R1", d, 0, "ctrl after reset");

    // R11: masked increment readback, unmapped address
    cur_req = "R11";
    wr(3'd4, 32'hFFFF8385);
    rd(3'd4, d); chk("R11", d, 32'h0000_0305, "inc readback");
    rd(3'd6, d); chk("R11", d, 0, "unmapped read");

    // R2: counting with steady and alternating ticks, and held without run
    cur_req = "R2";
    ticks(5, 0);
    chk("R2", count_o, 0, "no count without run bit");
    wr(3'd0, 32'h1);
    ticks(10, 0);
    ticks(12, 1);

    // R4: correction period zero -> exactly 8 * 5
    cur_req = "R4";
    wr(3'd1, 32'h0);
    ticks(8, 0);
    @(negedge clk);
    chk("R4", count_o, 32'd40, "eight ticks without correction");

    // R3: correction every 4th tick -> 6*5 + 2*3
    cur_req = "R3";
    wr(3'd3, 32'd3);
    wr(3'd1, 32'h0);
    ticks(8, 0);
    @(negedge clk);
    chk("R3", count_o, 32'd36, "eight ticks with correction period 3");
    ticks(15, 1);
    wr(3'd3, 32'd3);
    ticks(9, 0);
    wr(3'd3, 32'd0);

    // R5, R6: wrap at period with overshoot remainder, event gated off
    cur_req = "R5";
    wr(3'd2, 32'd100);
    wr(3'd1, 32'd97);
    wr(3'd0, 32'h31);
    ticks(1, 0);
    @(negedge clk);
    chk("R5", count_o, 32'd2, "wrap keeps remainder");
    ticks(60, 0);
    // R7: event enabled
    cur_req = "R7";
    wr(3'd0, 32'hB1);
    ticks(60, 0);

    // R8, R9: capture then read the held value while counting continues
    cur_req = "R8";
    @(posedge clk); #2;
    wr_en_i = 1; addr_i = 3'd0; wdata_i = 32'h8B1;
    @(posedge clk); #2;
    wr_en_i = 0; rd_en_i = 1; addr_i = 3'd0;
    @(posedge clk); #2;
    rd_en_i = 0;
    chk("R8", {31'b0, rdata_o[11]}, 1, "capture bit while pending");
    rd(3'd0, d); chk("R8", {31'b0, d[11]}, 0, "capture bit self-clear");
    cur_req = "R9";
    ticks(7, 0);
    rd(3'd1, d); chk("R9", d, m_cap, "time read returns captured value");

    // R10: load in the same cycle as a tick; R5 modulo wrap with period off
    cur_req = "R10";
    wr(3'd0, 32'h1);
    @(posedge clk); #2;
    tick_i = 1; wr_en_i = 1; addr_i = 3'd1; wdata_i = 32'hFFFF_FFFE;
    @(posedge clk); #2;
    wr_en_i = 0; tick_i = 0;
    @(negedge clk);
    chk("R10", count_o, 32'hFFFF_FFFE, "load beats tick");
    cur_req = "R5";
    ticks(1, 0);
    @(negedge clk);
    chk("R5", count_o, 32'd3, "modulo 2^32 with period wrap off");

    // 31-bit operation: period 2^31
    wr(3'd2, 32'h8000_0000);
    wr(3'd1, 32'h7FFF_FFF0);
    wr(3'd0, 32'hB1);
    ticks(6, 0);
    repeat (3) @(posedge clk);
    report();
  end
endmodule